// File: doc/BRIEF.md
# Logarithmic Pulse-Height Channel Converter

This block maps a wide linear pulse-height reading onto a compact logarithmic channel number, for use when binning detected particles by energy. A full base-2 logarithm table covering the whole input range would be far too large. Instead, the block halves the value one bit at a time until it fits a 512-entry table. Each halving adds a programmable scale constant to a running total, because that constant is the scaled logarithm of two.

The result is the table entry for the reduced value, plus the running total, plus a signed offset constant. That sum is divided by four with a two-bit right shift, and any negative sum is forced to zero. With suitably prepared contents, the output lands in roughly 0 to 128 channels. The table contents and the two constants are written through a simple address/data/write-enable port while the converter is idle. A conversion is requested with a one-cycle start pulse, and it ends with a one-cycle done pulse that comes with the channel value.

Top module: `logch_conv`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, busy, done and chan are all 0.
- R2: A start sampled while busy is 0 begins a conversion. If the input is 511 or less, done is 1 exactly one cycle after the accepting edge, and no scale constant is added.
- R3: While the working value is above 511, each cycle shifts it right by one bit and adds the scale constant to the accumulator. A conversion with n halvings raises done n+1 cycles after the accepting edge.
- R4: When done is high, chan equals (entry[v] + accumulator + offset) arithmetically shifted right by 2. Here v is the reduced value, entry is unsigned, the offset is a two's complement number, and the sum is computed without overflow.
- R5: If that sum is negative, chan is 0.
- R6: Table index 0 always reads as zero, and a write to address 0 has no effect.
- R7: A start while busy is 1 is ignored. It neither changes the result in progress nor produces an additional done.
- R8: A configuration write while busy is 1 is ignored.
- R9: cfg_addr 0..511 selects a table entry, cfg_addr 512 selects the unsigned scale constant, cfg_addr 513 selects the signed offset constant, and all other addresses are ignored.
- R10: done is a single-cycle pulse, and chan changes only on the cycle done rises, holding its value until the next done.
- R11: The largest 23-bit input needs 14 halvings, so done is high 15 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, sampled when idle |
| ph | input | PH_W (23) | Linear pulse height to convert |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse: chan holds a new result |
| chan | output | OUT_W (29) | Logarithmic channel result |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | TBL_AW+1 (10) | Table index, or 512 for scale, 513 for offset |
| cfg_data | input | WORD_W (24) | Configuration write data |

## Verification
Two functions can fall in the same cycle: a conversion that is halving, and a configuration write that targets the very table entry or scale constant that conversion will use. The bench provokes this by starting a conversion whose value reduces to index 511. While that conversion is still busy, it writes a new value to entry 511 and to the scale constant. The result and the latency must match the old contents. A second conversion of the same input must also return the old result, which shows at the ports that neither write landed. A start pulse given mid-conversion is judged the same way: it must not alter the result, and it must not add a done pulse.

// File: rtl/logch_conv.sv
module logch_conv #(
  parameter int PH_W   = 23,
  parameter int TBL_AW = 9,
  parameter int WORD_W = 24,
  localparam int TBL_N  = 1 << TBL_AW,
  localparam int STEPS  = PH_W - TBL_AW,
  localparam int ACC_W  = WORD_W + $clog2(STEPS + 1),
  localparam int SUM_W  = ACC_W + 2,
  localparam int OUT_W  = SUM_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [PH_W-1:0]   ph,
  output logic              busy,
  output logic              done,
  output logic [OUT_W-1:0]  chan,
  input  logic              cfg_we,
  input  logic [TBL_AW:0]   cfg_addr,
  input  logic [WORD_W-1:0] cfg_data
);

  logic [WORD_W-1:0] tbl [TBL_N];
  logic [WORD_W-1:0] scale;
  logic [WORD_W-1:0] offs;
  logic [PH_W-1:0]   val;
  logic [ACC_W-1:0]  acc;

  wire              wr_ok   = cfg_we && !busy;
  wire              wr_tbl  = wr_ok && !cfg_addr[TBL_AW] && (cfg_addr != '0);
  wire              wr_scl  = wr_ok && (cfg_addr == (TBL_AW+1)'(TBL_N));
  wire              wr_off  = wr_ok && (cfg_addr == (TBL_AW+1)'(TBL_N + 1));
  wire              wide    = |val[PH_W-1:TBL_AW];
  wire [TBL_AW-1:0] idx     = val[TBL_AW-1:0];
  wire [WORD_W-1:0] entry   = (idx == '0) ? '0 : tbl[idx];

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] shr;

  assign sum = $signed({{(SUM_W-WORD_W){1'b0}}, entry})
             + $signed({{(SUM_W-ACC_W){1'b0}}, acc})
             + $signed({{(SUM_W-WORD_W){offs[WORD_W-1]}}, offs});
  assign shr = sum >>> 2;

  always_ff @(posedge clk) begin
    if (wr_tbl) tbl[cfg_addr[TBL_AW-1:0]] <= cfg_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scale <= '0;
      offs  <= '0;
    end else begin
      if (wr_scl) scale <= cfg_data;
      if (wr_off) offs  <= cfg_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      chan <= '0;
      val  <= '0;
      acc  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          val  <= ph;
          acc  <= '0;
        end
      end else if (wide) begin
        val <= val >> 1;
        acc <= acc + {{(ACC_W-WORD_W){1'b0}}, scale};
      end else begin
        busy <= 1'b0;
        done <= 1'b1;
        chan <= shr[SUM_W-1] ? '0 : shr[OUT_W-1:0];
      end
    end
  end

endmodule

// File: rtl/logch_conv_chk.sv
module logch_conv_chk #(
  parameter int STEPS = 14,
  parameter int OUT_W = 29
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic [OUT_W-1:0] chan
);

  localparam int CW = $clog2(STEPS + 2) + 1;
  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)    run <= '0;
    else if (busy) run <= run + 1'b1;
    else           run <= '0;
  end

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_chan_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(chan));

  a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  a_r7_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r11_max_steps: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run <= CW'(STEPS)));

endmodule

bind logch_conv logch_conv_chk #(.STEPS(STEPS), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .busy(busy), .done(done), .chan(chan)
);

// File: tb/tb_logch_conv.sv
module tb_logch_conv;
  localparam int CLK_P  = 10;
  localparam int PH_W   = 23;
  localparam int TBL_AW = 9;
  localparam int WORD_W = 24;
  localparam int OUT_W  = 29;
  localparam int TBL_N  = 1 << TBL_AW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [PH_W-1:0]   ph = '0;
  logic              busy, done;
  logic [OUT_W-1:0]  chan;
  logic              cfg_we = 1'b0;
  logic [TBL_AW:0]   cfg_addr = '0;
  logic [WORD_W-1:0] cfg_data = '0;

  logic [WORD_W-1:0] m_tbl [TBL_N];
  logic [WORD_W-1:0] m_scale;
  logic [WORD_W-1:0] m_offs;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logch_conv #(.PH_W(PH_W), .TBL_AW(TBL_AW), .WORD_W(WORD_W)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ph(ph),
    .busy(busy), .done(done), .chan(chan),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  function automatic void model(input logic [PH_W-1:0] p, output longint res, output int n);
    longint v = p;
    longint acc = 0;
    longint s;
    longint e;
    n = 0;
    while (v > TBL_N - 1) begin
      v = v >> 1;
      acc += m_scale;
      n++;
    end
    e = (v == 0) ? 0 : m_tbl[v];
    s = e + acc + longint'($signed(m_offs));
    res = (s < 0) ? 0 : (s >>> 2);
  endfunction

  task automatic cfg(input int a, input logic [WORD_W-1:0] d, input bit upd);
    cfg_we = 1'b1; cfg_addr = (TBL_AW+1)'(a); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (upd) begin
      if (a == TBL_N)          m_scale = d;
      else if (a == TBL_N + 1) m_offs = d;
      else if (a > 0 && a < TBL_N) m_tbl[a] = d;
    end
  endtask

  task automatic conv(input logic [PH_W-1:0] p, input string req);
    longint e;
    int n;
    int cnt = 0;
    model(p, e, n);
    start = 1'b1; ph = p;
    @(negedge clk);
    start = 1'b0; ph = PH_W'($urandom);
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    chk(req, chan, e);
    chk({req, " latency"}, cnt, n + 1);
  endtask

  initial begin
    longint e;
    int n;
    int cnt;
    void'($urandom(32'd20240611));
    for (int i = 0; i < TBL_N; i++) m_tbl[i] = '0;
    m_scale = '0; m_offs = '0;

    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 chan", chan, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after", busy, 0); chk("R1 done after", done, 0); chk("R1 chan after", chan, 0);

    for (int i = 1; i < TBL_N; i++) cfg(i, WORD_W'($urandom_range(0, 1200)), 1);
    cfg(TBL_N, 24'd230, 1);
    cfg(TBL_N + 1, -24'sd900, 1);

    cfg(0, 24'd50000, 0);
    conv(23'd0, "R6 index zero");
    conv(23'd0, "R5 clamp");
    conv(23'd511, "R2 in range top");
    conv(23'd512, "R3 one halving");
    conv(23'd1023, "R3 boundary");
    conv(23'h7FFFFF, "R11 max input");

    cfg(TBL_N + 2, 24'd777, 0);
    cfg(1023, 24'd777, 0);
    conv(23'd7, "R9 unmapped address");

    model(23'h7FFFFF, e, n);
    start = 1'b1; ph = 23'h7FFFFF;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; ph = 23'd3;
    @(negedge clk);
    start = 1'b0;
    cnt = 2;
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    chk("R7 result", chan, e);
    chk("R7 latency", cnt, n + 1);
    repeat (3) begin
      @(negedge clk);
      chk("R7 no extra done", done, 0);
      chk("R10 chan held", chan, e);
    end

    model(23'h3FFFF, e, n);
    start = 1'b1; ph = 23'h3FFFF;
    @(negedge clk);
    start = 1'b0;
    cfg(511, 24'd60000, 0);
    cfg(TBL_N, 24'd9000, 0);
    cnt = 2;
    while (!done && cnt < 40) begin @(negedge clk); cnt++; end
    chk("R8 result", chan, e);
    chk("R8 latency", cnt, n + 1);
    @(negedge clk);
    chk("R10 done pulse", done, 0);
    conv(23'h3FFFF, "R8 state unchanged");

    cfg(TBL_N + 1, 24'd40, 1);
    cfg(TBL_N, 24'd4100, 1);
    cfg(300, 24'd1001, 1);
    conv(23'd300, "R9 table write");
    conv(23'd600, "R9 scale write");

    for (int k = 0; k < 300; k++) begin
      logic [PH_W-1:0] p;
      int sh = $urandom_range(0, PH_W - 1);
      p = PH_W'($urandom) >> sh;
      if (k % 50 == 0) cfg(TBL_N + 1, WORD_W'($urandom_range(0, 4000)) - 24'd2000, 1);
      conv(p, "R4 random");
    end

    finish_run();
  end
endmodule